// File: doc/BRIEF.md
# Physical register state tracker

This block keeps the lifecycle state of every entry in a unified physical register file. Each register carries three status bits: free, architectural and ready. Rename issue takes a free register from the block's allocator. Execution completion marks a register as holding a valid result. Commit promotes the committing result to architectural and releases the register that the same architectural register used before. Dispatch logic asks through two query ports whether a source register can be read.

When an exception or misprediction recovery happens, a single flush cycle returns every register in a used state to the free pool, and committed registers stay as they are. One allocate, one completion and one commit are accepted each cycle. Events that do not fit the current state of their register are dropped, and the block reports them on an error flag.

Top module: `preg_state_tracker`

## Requirements
- R1: After reset, registers 0 to NUM_AREGS-1 are architectural and all others are free. The state bits (free, arch, ready) take only these values: 100 free, 000 used-not-ready, 001 used-ready, 011 architectural.
- R2: `alloc_tag_o` gives the lowest-numbered free register. `stall_o` is high exactly when no register is free.
- R3: `alloc_gnt_o` equals `alloc_req_i & !stall_o & !flush_i`. On a grant, the offered register becomes used-not-ready at the next clock edge.
- R4: A completion for a used-not-ready register makes it used-ready at the next edge.
- R5: A commit whose new register is used-ready and whose old register is architectural makes the new register architectural and the old register free at the next edge.
- R6: A query output is high exactly when the queried register is used-ready or architectural.
- R7: In a flush cycle, every used register becomes free at the next edge and architectural registers keep their state. Completion and commit inputs in that cycle are ignored and raise no error.
- R8: An allocate request in a flush cycle is refused.
- R9: Outside a flush cycle, a completion or commit that does not match a legal transition (including a tag at or above NUM_PREGS) leaves every state unchanged and sets `err_o` in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| alloc_req_i | input | 1 | Issue requests a destination register |
| alloc_gnt_o | output | 1 | Request granted this cycle |
| alloc_tag_o | output | TAG_W | Lowest free register |
| stall_o | output | 1 | No free register |
| cmpl_valid_i | input | 1 | Completion event |
| cmpl_tag_i | input | TAG_W | Register written by the completing instruction |
| cmt_valid_i | input | 1 | Commit event |
| cmt_new_tag_i | input | TAG_W | Register of the committing result |
| cmt_old_tag_i | input | TAG_W | Register previously mapped to the same architectural register |
| flush_i | input | 1 | Recovery: release all used registers |
| qry_a_tag_i | input | TAG_W | First source operand query |
| qry_a_rdy_o | output | 1 | First source readable |
| qry_b_tag_i | input | TAG_W | Second source operand query |
| qry_b_rdy_o | output | 1 | Second source readable |
| err_o | output | 1 | Illegal event seen in the previous cycle |

## Verification
The bench builds the block with NUM_PREGS = 40 and NUM_AREGS = 32. This leaves only eight renaming registers, so the allocator runs out often and the stall path and the lowest-free priority get exercised under constant pressure. Because 40 is not a power of two, the six-bit tags can also name registers that do not exist, and this drives out-of-range completions and commits into the error path. Random flushes land while registers are in every state, so recovery is checked against mixes of used-ready and used-not-ready entries.

// File: rtl/preg_pkg.sv
package preg_pkg;
  typedef struct packed {
    logic free;
    logic arch;
    logic ready;
  } preg_st_t;

  localparam preg_st_t ST_FREE    = '{free: 1'b1, arch: 1'b0, ready: 1'b0};
  localparam preg_st_t ST_USED_NR = '{free: 1'b0, arch: 1'b0, ready: 1'b0};
  localparam preg_st_t ST_USED_R  = '{free: 1'b0, arch: 1'b0, ready: 1'b1};
  localparam preg_st_t ST_ARCH    = '{free: 1'b0, arch: 1'b1, ready: 1'b1};
endpackage

// File: rtl/preg_pick.sv
module preg_pick #(
  parameter int N = 64,
  parameter int W = $clog2(N)
) (
  input  logic [N-1:0] free_i,
  output logic         found_o,
  output logic [W-1:0] idx_o
);
  // scan downward so the lowest set bit wins
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (free_i[i]) begin
        found_o = 1'b1;
        idx_o   = W'(i);
      end
    end
  end
endmodule

// File: rtl/preg_entry.sv
module preg_entry
  import preg_pkg::*;
#(
  parameter bit RESET_ARCH = 1'b0
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     flush_i,
  input  logic     alloc_i,
  input  logic     cmpl_i,
  input  logic     promote_i,
  input  logic     release_i,
  output preg_st_t st_o
);
  preg_st_t st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= RESET_ARCH ? ST_ARCH : ST_FREE;
    end else if (flush_i) begin
      if (!st_q.free && !st_q.arch) st_q <= ST_FREE;
    end else if (alloc_i) begin
      st_q <= ST_USED_NR;
    end else if (cmpl_i) begin
      st_q <= ST_USED_R;
    end else if (promote_i) begin
      st_q <= ST_ARCH;
    end else if (release_i) begin
      st_q <= ST_FREE;
    end
  end

  assign st_o = st_q;
endmodule

// File: rtl/preg_state_tracker.sv
module preg_state_tracker
  import preg_pkg::*;
#(
  parameter int NUM_PREGS = 64,
  parameter int NUM_AREGS = 32,
  parameter int TAG_W     = $clog2(NUM_PREGS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             alloc_req_i,
  output logic             alloc_gnt_o,
  output logic [TAG_W-1:0] alloc_tag_o,
  output logic             stall_o,
  input  logic             cmpl_valid_i,
  input  logic [TAG_W-1:0] cmpl_tag_i,
  input  logic             cmt_valid_i,
  input  logic [TAG_W-1:0] cmt_new_tag_i,
  input  logic [TAG_W-1:0] cmt_old_tag_i,
  input  logic             flush_i,
  input  logic [TAG_W-1:0] qry_a_tag_i,
  output logic             qry_a_rdy_o,
  input  logic [TAG_W-1:0] qry_b_tag_i,
  output logic             qry_b_rdy_o,
  output logic             err_o
);
  localparam int ST_W = $bits(preg_st_t);

  preg_st_t                   st [NUM_PREGS];
  logic [NUM_PREGS-1:0]       free_vec;
  logic [NUM_PREGS*ST_W-1:0]  st_flat;
  logic                       found;
  preg_st_t                   cmpl_st, new_st, old_st;
  logic                       cmpl_ok, cmt_ok, err_d, err_q;

  preg_pick #(.N(NUM_PREGS), .W(TAG_W)) u_pick (
    .free_i (free_vec),
    .found_o(found),
    .idx_o  (alloc_tag_o)
  );

  assign stall_o     = !found;
  assign alloc_gnt_o = alloc_req_i && found && !flush_i;

  // out-of-range tags read back as free, which no event accepts
  always_comb begin
    cmpl_st     = ST_FREE;
    new_st      = ST_FREE;
    old_st      = ST_FREE;
    qry_a_rdy_o = 1'b0;
    qry_b_rdy_o = 1'b0;
    for (int i = 0; i < NUM_PREGS; i++) begin
      if (cmpl_tag_i == TAG_W'(i))    cmpl_st = st[i];
      if (cmt_new_tag_i == TAG_W'(i)) new_st  = st[i];
      if (cmt_old_tag_i == TAG_W'(i)) old_st  = st[i];
      if (qry_a_tag_i == TAG_W'(i))   qry_a_rdy_o = st[i].ready;
      if (qry_b_tag_i == TAG_W'(i))   qry_b_rdy_o = st[i].ready;
    end
  end

  assign cmpl_ok = cmpl_valid_i && (cmpl_st == ST_USED_NR);
  assign cmt_ok  = cmt_valid_i && (new_st == ST_USED_R) && (old_st == ST_ARCH);
  assign err_d   = !flush_i && ((cmpl_valid_i && !cmpl_ok) || (cmt_valid_i && !cmt_ok));

  for (genvar g = 0; g < NUM_PREGS; g++) begin : g_entry
    preg_entry #(.RESET_ARCH(g < NUM_AREGS)) u_entry (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .flush_i  (flush_i),
      .alloc_i  (alloc_gnt_o && (alloc_tag_o == TAG_W'(g))),
      .cmpl_i   (cmpl_ok && (cmpl_tag_i == TAG_W'(g))),
      .promote_i(cmt_ok && (cmt_new_tag_i == TAG_W'(g))),
      .release_i(cmt_ok && (cmt_old_tag_i == TAG_W'(g))),
      .st_o     (st[g])
    );
    assign free_vec[g]                 = st[g].free;
    assign st_flat[g*ST_W +: ST_W]     = st[g];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= err_d;
  end

  assign err_o = err_q;
endmodule

// File: rtl/preg_tracker_chk.sv
module preg_tracker_chk #(
  parameter int NUM_PREGS = 64,
  parameter int TAG_W     = $clog2(NUM_PREGS)
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  alloc_req_i,
  input logic                  alloc_gnt_o,
  input logic [TAG_W-1:0]      alloc_tag_o,
  input logic                  stall_o,
  input logic                  cmpl_valid_i,
  input logic [TAG_W-1:0]      cmpl_tag_i,
  input logic                  flush_i,
  input logic                  err_o,
  input logic [NUM_PREGS*3-1:0] st_flat
);
  function automatic logic [2:0] st_of(logic [NUM_PREGS*3-1:0] v, logic [TAG_W-1:0] t);
    logic [2:0] r;
    r = 3'b100;
    for (int i = 0; i < NUM_PREGS; i++) if (t == TAG_W'(i)) r = v[i*3 +: 3];
    return r;
  endfunction

  function automatic logic all_legal(logic [NUM_PREGS*3-1:0] v);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < NUM_PREGS; i++)
      if (!(v[i*3 +: 3] inside {3'b100, 3'b000, 3'b001, 3'b011})) ok = 1'b0;
    return ok;
  endfunction

  function automatic logic none_used(logic [NUM_PREGS*3-1:0] v);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < NUM_PREGS; i++)
      if (v[i*3 + 2] == 1'b0 && v[i*3 + 1] == 1'b0) ok = 1'b0;
    return ok;
  endfunction

  logic             gnt_q, cmpl_ok_q, flush_q;
  logic [TAG_W-1:0] gtag_q, ctag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gnt_q <= 1'b0; cmpl_ok_q <= 1'b0; flush_q <= 1'b0;
      gtag_q <= '0;  ctag_q <= '0;
    end else begin
      gnt_q     <= alloc_gnt_o;
      gtag_q    <= alloc_tag_o;
      cmpl_ok_q <= cmpl_valid_i && !flush_i && (st_of(st_flat, cmpl_tag_i) == 3'b000);
      ctag_q    <= cmpl_tag_i;
      flush_q   <= flush_i;
    end
  end

  // R1
  legal_enc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) all_legal(st_flat));
  // R2
  stall_free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stall_o |-> st_of(st_flat, alloc_tag_o) == 3'b100);
  // R3
  alloc_used_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_q |-> st_of(st_flat, gtag_q) == 3'b000);
  // R3
  no_gnt_on_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> !alloc_gnt_o);
  // R4
  cmpl_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmpl_ok_q |-> st_of(st_flat, ctag_q) == 3'b001);
  // R7
  flush_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_q |-> none_used(st_flat));
  // R8
  flush_no_alloc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |-> !alloc_gnt_o);
  // R9
  flush_no_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !err_o);
  // R9
  bad_cmpl_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmpl_valid_i && !flush_i && st_of(st_flat, cmpl_tag_i) != 3'b000) |=> err_o);
endmodule

bind preg_state_tracker preg_tracker_chk #(.NUM_PREGS(NUM_PREGS), .TAG_W(TAG_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .alloc_req_i (alloc_req_i),
  .alloc_gnt_o (alloc_gnt_o),
  .alloc_tag_o (alloc_tag_o),
  .stall_o     (stall_o),
  .cmpl_valid_i(cmpl_valid_i),
  .cmpl_tag_i  (cmpl_tag_i),
  .flush_i     (flush_i),
  .err_o       (err_o),
  .st_flat     (st_flat)
);

// File: tb/tb_preg_state_tracker.sv
`timescale 1ns/1ps
module tb_preg_state_tracker;
  localparam int NP = 40;
  localparam int NA = 32;
  localparam int TW = $clog2(NP);

  logic          clk_i = 1'b0, rst_ni = 1'b0;
  logic          alloc_req_i = 1'b0, alloc_gnt_o, stall_o;
  logic [TW-1:0] alloc_tag_o;
  logic          cmpl_valid_i = 1'b0, cmt_valid_i = 1'b0, flush_i = 1'b0;
  logic [TW-1:0] cmpl_tag_i = '0, cmt_new_tag_i = '0, cmt_old_tag_i = '0;
  logic [TW-1:0] qry_a_tag_i = '0, qry_b_tag_i = '0;
  logic          qry_a_rdy_o, qry_b_rdy_o, err_o;

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic [2:0] ms [NP];
  logic       exp_err = 1'b0;

  always #2 clk_i = ~clk_i;

  preg_state_tracker #(.NUM_PREGS(NP), .NUM_AREGS(NA)) dut (.*);

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic logic [2:0] mst(input int t);
    return (t < NP) ? ms[t] : 3'b100;
  endfunction

  function automatic int low_free();
    for (int i = 0; i < NP; i++) if (ms[i] == 3'b100) return i;
    return -1;
  endfunction

  function automatic int find_st(input logic [2:0] s);
    int st0 = $urandom % NP;
    for (int k = 0; k < NP; k++) if (ms[(st0 + k) % NP] == s) return (st0 + k) % NP;
    return -1;
  endfunction

  task automatic check_state();
    int lf;
    logic ea, eb;
    qry_a_tag_i = TW'($urandom % 48);
    qry_b_tag_i = TW'($urandom % NP);
    #0.5;
    lf = low_free();
    ea = mst(int'(qry_a_tag_i)) inside {3'b001, 3'b011};
    eb = mst(int'(qry_b_tag_i)) inside {3'b001, 3'b011};
    chk(qry_a_rdy_o == ea, "R6 qry_a", qry_a_rdy_o, ea);
    chk(qry_b_rdy_o == eb, "R6 qry_b", qry_b_rdy_o, eb);
    chk(stall_o == (lf < 0), "R2 stall", stall_o, lf < 0);
    if (lf >= 0) chk(int'(alloc_tag_o) == lf, "R2 lowest free", alloc_tag_o, lf);
    chk(err_o == exp_err, "R9 err", err_o, exp_err);
  endtask

  // drive one cycle of events, predict, then wait for the edge
  task automatic step(input logic req, input logic fl, input logic cv, input int ct,
                      input logic mv, input int nt, input int ot);
    int lf;
    logic gnt_e, c_ok, m_ok;
    alloc_req_i = req; flush_i = fl;
    cmpl_valid_i = cv; cmpl_tag_i = TW'(ct);
    cmt_valid_i = mv; cmt_new_tag_i = TW'(nt); cmt_old_tag_i = TW'(ot);
    #0.5;
    lf    = low_free();
    gnt_e = req && (lf >= 0) && !fl;
    chk(alloc_gnt_o == gnt_e, fl ? "R8 gnt in flush" : "R3 gnt", alloc_gnt_o, gnt_e);
    c_ok = cv && mst(ct) == 3'b000;
    m_ok = mv && mst(nt) == 3'b001 && mst(ot) == 3'b011;
    if (fl) begin
      for (int i = 0; i < NP; i++) if (ms[i] inside {3'b000, 3'b001}) ms[i] = 3'b100;
      exp_err = 1'b0;
    end else begin
      if (gnt_e) ms[lf] = 3'b000;
      if (c_ok) ms[ct] = 3'b001;
      if (m_ok) begin ms[nt] = 3'b011; ms[ot] = 3'b100; end
      exp_err = (cv && !c_ok) || (mv && !m_ok);
    end
    @(posedge clk_i);
    @(negedge clk_i);
    cyc++;
    check_state();
  endtask

  initial begin
    for (int i = 0; i < NP; i++) ms[i] = (i < NA) ? 3'b011 : 3'b100;
    void'($urandom(32'h5eed_0042));
    #9 rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    qry_a_tag_i = TW'(NA - 1); qry_b_tag_i = TW'(NA);
    #0.5;
    chk(qry_a_rdy_o == 1'b1, "R1 last arch reg ready", qry_a_rdy_o, 1);
    chk(qry_b_rdy_o == 1'b0, "R1 first rename reg free", qry_b_rdy_o, 0);
    chk(int'(alloc_tag_o) == NA, "R1 first free tag", alloc_tag_o, NA);
    check_state();
    // directed: fill the pool to reach stall (R2, R3)
    for (int i = 0; i < NP - NA + 1; i++) step(1, 0, 0, 0, 0, 0, 0);
    chk(stall_o == 1'b1, "R2 stall when full", stall_o, 1);
    // R4 complete, R5 commit onto arch reg 5
    step(0, 0, 1, NA + 2, 0, 0, 0);
    step(0, 0, 0, 0, 1, NA + 2, 5);
    chk(int'(alloc_tag_o) == 5, "R5 old reg freed", alloc_tag_o, 5);
    // R9 illegal commit: new not ready
    step(0, 0, 0, 0, 1, NA + 3, 6);
    // R9 out-of-range completion
    step(0, 0, 1, 45, 0, 0, 0);
    // R7 flush ignores events; R8 refuses allocate
    step(1, 1, 1, NA + 4, 1, NA + 2, 7);
    chk(int'(alloc_tag_o) == 5, "R7 flush keeps lowest free", alloc_tag_o, 5);
    // random phase
    for (int n = 0; n < 4000; n++) begin
      logic fl, cv, mv;
      int ct, nt, ot;
      fl = ($urandom % 40) == 0;
      cv = ($urandom % 2) == 0;
      ct = find_st(3'b000);
      if (ct < 0 || ($urandom % 16) == 0) ct = $urandom % 64;
      mv = ($urandom % 5) < 2;
      nt = find_st(3'b001);
      ot = find_st(3'b011);
      if (nt < 0 || ($urandom % 16) == 0) nt = $urandom % NP;
      if (ot < 0) ot = $urandom % NP;
      step(($urandom % 4) != 0, fl, cv, ct % 64, mv, nt, ot);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule